// File: doc/BRIEF.md
# Ring Signal Wake Detector

This block watches a telephone-line ring indication and turns it into a single wake strobe for the power controller. One of two ring pins is chosen by a select bit. The chosen pin passes through a two-flop synchroniser, and its falling edges are then found.

Two detection styles are offered. In edge mode, every falling edge of the chosen pin raises a wake strobe. In train mode, the falling edges must keep coming fast enough, with no interval longer than one sixteenth of a second. They must also go on doing so for roughly 0.19 s before one strobe is issued. Train mode rejects line noise, single glitches and slow ringing.

All timing is counted in pulses of a free-running clock-enable tick. The limits are parameters, so the same logic serves any tick rate. A reduced rate can be used in simulation.

Top module: `ring_wake_detector`

## Requirements
- R1: `ring_sel_i` = 0 routes `ring_a_i` to the detector and `ring_sel_i` = 1 routes `ring_b_i`. Falling edges on the pin that is not selected never cause a strobe.
- R2: The selected pin passes through two synchroniser flops, an edge register and the output register. A falling edge driven just after a rising clock edge makes `wake_o` high after the fourth rising edge that follows, and not before.
- R3: With `ring_mode_i` = 0 (edge mode) and `ring_en_i` = 1, every falling edge of the selected pin produces exactly one wake strobe, provided the edges are several clock cycles apart.
- R4: While `ring_en_i` = 0, no strobe is produced in either mode, and any partly qualified train is discarded.
- R5: `wake_o` is never high for two consecutive clock cycles.
- R6: With `ring_mode_i` = 1 (train mode), one strobe is produced once QUAL_TICKS ticks have been counted since the first falling edge of a train. During that time no GAP_TICKS ticks may pass without a falling edge.
- R7: When GAP_TICKS ticks pass with no falling edge, the train ends and its accumulated duration is cleared. A train whose edges are further apart than this never produces a strobe.
- R8: After a train strobe, no further strobe is produced while that train continues. A new strobe needs the train to end and a fresh qualification to complete.
- R9: An interval between falling edges that is shorter than GAP_TICKS ticks does not reset the accumulated duration, even when it is longer than the usual ring period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timing tick that sets the time base of the train qualifier |
| ring_a_i | input | 1 | First ring pin, asynchronous, idle high |
| ring_b_i | input | 1 | Second ring pin, asynchronous, idle high |
| ring_sel_i | input | 1 | Pin select: 0 for `ring_a_i`, 1 for `ring_b_i` |
| ring_mode_i | input | 1 | Detection style: 0 for edge, 1 for pulse train |
| ring_en_i | input | 1 | Ring wake enable |
| wake_o | output | 1 | One-cycle wake strobe to the power controller |

## Verification
A stuck or skipped synchroniser stage shows up as a shift in the four-cycle edge-to-strobe latency, and the latency check pins this down to the cycle. A gap counter that never saturates or never times out has one of two effects. Either slow ringing wakes the system, or accumulated duration survives a pause. Either way the error appears as a wrong strobe count within one qualification window after the train ends. A duration counter that is not frozen after firing produces repeated strobes during a long train, and this becomes visible QUAL_TICKS ticks after the first strobe.

// File: rtl/ring_wake_pkg.sv
package ring_wake_pkg;

  typedef enum logic {
    DET_EDGE  = 1'b0,
    DET_TRAIN = 1'b1
  } det_mode_e;

  // Width needed to hold values 0..max_val
  function automatic int unsigned span_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/ring_pin_sync.sv
module ring_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic pin_a_i,
  input  logic pin_b_i,
  output logic fall_o
);

  logic                   pin_mux;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic                   fall_q;

  assign pin_mux = sel_i ? pin_b_i : pin_a_i;

  // Synchroniser chain, idle level high so reset creates no edge
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= pin_mux;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= 1'b1;
      fall_q <= 1'b0;
    end else begin
      hist_q <= sync_q[SYNC_STAGES-1];
      fall_q <= hist_q & ~sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = fall_q;

endmodule

// File: rtl/ring_train_qual.sv
module ring_train_qual
  import ring_wake_pkg::*;
#(
  parameter int unsigned GAP_TICKS  = 125,
  parameter int unsigned QUAL_TICKS = 380
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  input  logic fall_i,
  output logic hit_o,
  output logic fired_o
);

  localparam int unsigned GW = span_w(GAP_TICKS);
  localparam int unsigned DW = span_w(QUAL_TICKS);
  localparam logic [GW-1:0] GAP_MAX  = GW'(GAP_TICKS);
  localparam logic [DW-1:0] DUR_LAST = DW'(QUAL_TICKS - 1);

  logic [GW-1:0] gap_q;
  logic [DW-1:0] dur_q;
  logic          active_q;
  logic          fired_q;
  logic          hit_q;

  logic gap_full;
  logic timeout;
  logic dur_last;
  logic count_en;

  assign gap_full = (gap_q == GAP_MAX);
  assign timeout  = active_q && gap_full && !fall_i;
  assign dur_last = (dur_q == DUR_LAST);
  assign count_en = active_q && !fired_q && tick_i && !timeout;

  // Ticks since the latest falling edge, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      gap_q <= GAP_MAX;
    end else if (fall_i) begin
      gap_q <= '0;
    end else if (tick_i && !gap_full) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // Train state and accumulated duration
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      active_q <= 1'b0;
      fired_q  <= 1'b0;
      dur_q    <= '0;
      hit_q    <= 1'b0;
    end else begin
      hit_q <= count_en && dur_last;
      if (timeout) begin
        active_q <= 1'b0;
        fired_q  <= 1'b0;
        dur_q    <= '0;
      end else if (fall_i && !active_q) begin
        active_q <= 1'b1;
        dur_q    <= '0;
      end else if (count_en) begin
        dur_q <= dur_q + 1'b1;
        if (dur_last) fired_q <= 1'b1;
      end
    end
  end

  assign hit_o   = hit_q;
  assign fired_o = fired_q;

endmodule

// File: rtl/ring_wake_out.sv
module ring_wake_out
  import ring_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  det_mode_e mode_i,
  input  logic      en_i,
  input  logic      fall_i,
  input  logic      hit_i,
  output logic      wake_o
);

  logic wake_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q <= 1'b0;
    end else begin
      wake_q <= en_i && ((mode_i == DET_TRAIN) ? hit_i : fall_i);
    end
  end

  assign wake_o = wake_q;

endmodule

// File: rtl/ring_wake_detector.sv
module ring_wake_detector
  import ring_wake_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GAP_TICKS   = 125,
  parameter int unsigned QUAL_TICKS  = 380
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic ring_a_i,
  input  logic ring_b_i,
  input  logic ring_sel_i,
  input  logic ring_mode_i,
  input  logic ring_en_i,
  output logic wake_o
);

  logic      fall_s;
  logic      hit_s;
  logic      fired_s;
  det_mode_e mode_s;

  assign mode_s = det_mode_e'(ring_mode_i);

  ring_pin_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (ring_sel_i),
    .pin_a_i (ring_a_i),
    .pin_b_i (ring_b_i),
    .fall_o  (fall_s)
  );

  ring_train_qual #(
    .GAP_TICKS  (GAP_TICKS),
    .QUAL_TICKS (QUAL_TICKS)
  ) u_qual (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (!ring_en_i),
    .tick_i  (tick_i),
    .fall_i  (fall_s),
    .hit_o   (hit_s),
    .fired_o (fired_s)
  );

  ring_wake_out u_out (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_s),
    .en_i   (ring_en_i),
    .fall_i (fall_s),
    .hit_i  (hit_s),
    .wake_o (wake_o)
  );

endmodule

// File: rtl/ring_wake_chk.sv
module ring_wake_chk (
  input logic clk,
  input logic rst,
  input logic ring_en_i,
  input logic ring_mode_i,
  input logic fall_s,
  input logic hit_s,
  input logic fired_s,
  input logic wake_o
);

  p_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);

  p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    !ring_en_i |=> !wake_o);

  p_edge_wakes_r3: assert property (@(posedge clk) disable iff (rst)
    (fall_s && !ring_mode_i && ring_en_i) |=> wake_o);

  p_train_wakes_r6: assert property (@(posedge clk) disable iff (rst)
    (hit_s && ring_mode_i && ring_en_i) |=> wake_o);

  p_wake_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(fall_s || hit_s));

  p_hit_latches_r8: assert property (@(posedge clk) disable iff (rst)
    hit_s |-> fired_s);

  p_no_rehit_r8: assert property (@(posedge clk) disable iff (rst)
    (fired_s && $past(fired_s)) |-> !hit_s);

endmodule

bind ring_wake_detector ring_wake_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .ring_en_i   (ring_en_i),
  .ring_mode_i (ring_mode_i),
  .fall_s      (fall_s),
  .hit_s       (hit_s),
  .fired_s     (fired_s),
  .wake_o      (wake_o)
);

// File: tb/ring_wake_detector_tb_top.sv
`timescale 1ns/1ps
module ring_wake_detector_tb_top;

  localparam int GAP  = 8;
  localparam int QUAL = 20;
  localparam int TDIV = 4;   // clocks per tick
  localparam int NVEC = 11;

  // {sel, mode, en, pin_b, edges[5:0], interval_cycles[7:0], expected[1:0]}
  localparam logic [19:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 6'd3,  8'd80, 2'd3},  // R1 R3 edge on pin a
    {1'b1, 1'b0, 1'b1, 1'b1, 6'd2,  8'd80, 2'd2},  // R1 R3 edge on pin b
    {1'b0, 1'b0, 1'b1, 1'b1, 6'd3,  8'd80, 2'd0},  // R1 unselected b
    {1'b1, 1'b0, 1'b1, 1'b0, 6'd3,  8'd80, 2'd0},  // R1 unselected a
    {1'b0, 1'b0, 1'b0, 1'b0, 6'd3,  8'd80, 2'd0},  // R4 edge disabled
    {1'b0, 1'b1, 1'b1, 1'b0, 6'd10, 8'd16, 2'd1},  // R6 fast long train
    {1'b0, 1'b1, 1'b1, 1'b0, 6'd3,  8'd16, 2'd0},  // R6 too short
    {1'b0, 1'b1, 1'b1, 1'b0, 6'd10, 8'd40, 2'd0},  // R7 too slow
    {1'b0, 1'b1, 1'b1, 1'b0, 6'd30, 8'd16, 2'd1},  // R8 single strobe
    {1'b0, 1'b1, 1'b0, 1'b0, 6'd10, 8'd16, 2'd0},  // R4 train disabled
    {1'b1, 1'b1, 1'b1, 1'b1, 6'd10, 8'd16, 2'd1}   // R1 R6 train on pin b
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic ring_a_i = 1'b1;
  logic ring_b_i = 1'b1;
  logic ring_sel_i = 1'b0;
  logic ring_mode_i = 1'b0;
  logic ring_en_i = 1'b0;
  logic wake_o;

  int checks = 0;
  int fails = 0;
  int wake_cnt = 0;
  logic wake_prev = 1'b0;
  int tdiv_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ring_wake_detector #(
    .SYNC_STAGES (2),
    .GAP_TICKS   (GAP),
    .QUAL_TICKS  (QUAL)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .ring_a_i    (ring_a_i),
    .ring_b_i    (ring_b_i),
    .ring_sel_i  (ring_sel_i),
    .ring_mode_i (ring_mode_i),
    .ring_en_i   (ring_en_i),
    .wake_o      (wake_o)
  );

  always @(negedge clk) begin
    tdiv_cnt = (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    tick_i   = (tdiv_cnt == 0);
  end

  // Strobe counter and width monitor (R5)
  always @(negedge clk) begin
    if (!rst) begin
      if (wake_o) wake_cnt++;
      if (wake_o && wake_prev) begin
        fails++;
        $display("FAIL R5: wake_o high two cycles, actual=1 expected=0");
      end
    end
    wake_prev = wake_o;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulses(input bit use_b, input int n, input int interval);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (use_b) ring_b_i = 1'b0; else ring_a_i = 1'b0;
      repeat (8) @(posedge clk);
      #1;
      if (use_b) ring_b_i = 1'b1; else ring_a_i = 1'b1;
      repeat (interval - 8) @(posedge clk);
    end
  endtask

  task automatic idle_out();
    repeat ((GAP + 6) * TDIV) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R5 reset", int'(wake_o), 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (20) @(negedge clk);
    check("R3 idle after reset", wake_cnt, 0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [19:0] e;
      e = VECS[v];
      @(posedge clk); #1;
      ring_sel_i  = e[19];
      ring_mode_i = e[18];
      ring_en_i   = e[17];
      idle_out();
      wake_cnt = 0;
      pulses(e[16], int'(e[15:10]), int'(e[9:2]));
      idle_out();
      @(negedge clk);
      check($sformatf("R1/R3/R4/R6/R7/R8 vector %0d", v), wake_cnt, int'(e[1:0]));
    end

    // R2: edge-to-strobe latency
    @(posedge clk); #1;
    ring_sel_i = 1'b0; ring_mode_i = 1'b0; ring_en_i = 1'b1;
    idle_out();
    @(posedge clk); #1 ring_a_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 no strobe after 3 edges", int'(wake_o), 0);
    @(negedge clk);
    check("R2 strobe after 4 edges", int'(wake_o), 1);
    @(negedge clk);
    check("R5 strobe ends", int'(wake_o), 0);
    @(posedge clk); #1 ring_a_i = 1'b1;
    idle_out();

    // R9: short pause keeps duration
    @(posedge clk); #1 ring_mode_i = 1'b1;
    idle_out();
    wake_cnt = 0;
    pulses(1'b0, 3, 16);
    repeat (8) @(posedge clk);
    pulses(1'b0, 3, 16);
    idle_out();
    check("R9 short pause train fires", wake_cnt, 1);

    // R7: long pause clears duration
    wake_cnt = 0;
    pulses(1'b0, 3, 16);
    repeat (32) @(posedge clk);
    pulses(1'b0, 3, 16);
    idle_out();
    check("R7 long pause resets", wake_cnt, 0);

    // R4: disable mid-train discards progress
    wake_cnt = 0;
    pulses(1'b0, 4, 16);
    #1 ring_en_i = 1'b0;
    repeat (2) @(posedge clk);
    #1 ring_en_i = 1'b1;
    pulses(1'b0, 3, 16);
    idle_out();
    check("R4 disable clears train", wake_cnt, 0);

    // R8: requalification after the train ends
    wake_cnt = 0;
    pulses(1'b0, 10, 16);
    idle_out();
    pulses(1'b0, 10, 16);
    idle_out();
    check("R8 two trains two strobes", wake_cnt, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule